// File: doc/BRIEF.md
# Partial Register Merge Tracker

This block sits in the rename stage and tracks byte-slice writes to a small set of architectural general registers. Each register has a low byte, a high byte (bits 15:8), and 16-, 32- and 64-bit forms. The low byte is never renamed on its own: any write to it is handled as a read-modify-write of the whole register, so it merges at no cost. The high byte can be renamed on its own. While a register's renamed high byte is held apart from the rest of the register, its high-byte dirty bit is set.

One decoded micro-op arrives per cycle. It carries a destination register, a destination slice and a flag that says whether the destination is also read. It also carries up to two source registers, each with its own slice. If the micro-op reads a wider form of a register whose high byte is dirty, or writes that register's 16-bit form, the tracker inserts a merge micro-op. It deasserts `in_ready` for that cycle, pulses `merge_vld` with the register index, clears the dirty bit, and accepts the held micro-op in a later cycle.

For each accepted micro-op the tracker also reports whether one extra cycle of latency applies to all of its operands. This happens when the micro-op reads a high byte that is not dirty.

Top module: `prt_merge_tracker`

## Requirements
- R1: Slice codes are 0 low byte, 1 high byte, 2 16-bit, 3 32-bit, 4 64-bit. A micro-op that only reads or writes low-byte slices never causes a merge and leaves every dirty bit unchanged, including set ones.
- R2: An accepted micro-op whose destination slice is the high byte (code 1) and whose destination-read flag is 0 sets that register's dirty bit, with no merge.
- R3: An accepted high-byte destination with the destination-read flag at 1 sets the dirty bit if it was clear. If it was already set, no merge occurs and the bit stays set.
- R4: When a valid micro-op reads the 16-, 32- or 64-bit form of a register whose dirty bit is set, `in_ready` is 0 in that cycle. `merge_vld` pulses with `merge_reg` set to that register after the next edge, and the bit is cleared. The micro-op is accepted in a later cycle, and `iss_vld` pulses one edge after acceptance.
- R5: An accepted write-only destination of slice 3 or 4 clears that register's dirty bit without a merge.
- R6: A destination of slice 2 (16-bit) on a register whose dirty bit is set causes a merge first, even when the destination-read flag is 0.
- R7: `extra_lat` pulses with `iss_vld` when the accepted micro-op reads a high-byte slice (as a source or as a read destination) of a register whose dirty bit is clear. It stays 0 when every high byte read is dirty.
- R8: Dirty bits persist across any number of idle cycles and unrelated micro-ops.
- R9: Reset clears all dirty bits and outputs. A `flush` cycle clears all dirty bits, holds `in_ready` at 0, and produces neither an issue nor a merge.
- R10: When several registers need a merge, merges are inserted one per cycle, lowest register index first, and the micro-op is accepted only after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Pipeline flush, clears all dirty state |
| in_valid | input | 1 | Micro-op descriptor is present |
| in_ready | output | 1 | Descriptor is accepted this cycle |
| dst_vld | input | 1 | Micro-op has a destination |
| dst_reg | input | RW | Destination register index |
| dst_slice | input | 3 | Destination slice code |
| dst_rd | input | 1 | Destination is also read |
| src_vld | input | NSRC | Per-source valid |
| src_reg | input | NSRC*RW | Packed source register indices |
| src_slice | input | NSRC*3 | Packed source slice codes |
| iss_vld | output | 1 | Pulse: micro-op issued |
| merge_vld | output | 1 | Pulse: merge micro-op inserted |
| merge_reg | output | RW | Register merged by the pulse |
| extra_lat | output | 1 | Issued micro-op takes one extra cycle of latency |
| dirty | output | NREG | Per-register high-byte dirty bits |

## Verification
`in_ready` is combinational, so the bench reads it one time step after driving the inputs, in the same cycle. `iss_vld`, `merge_vld`, `merge_reg`, `extra_lat` and `dirty` change at the first rising edge after the deciding cycle. The bench drives on the falling edge, lets the reference model advance at the rising edge, and compares all registered outputs at the following falling edge. A micro-op that needs merges is re-offered each cycle until the model reports acceptance. As a result, each merge pulse is checked one edge after its stall cycle, and the issue pulse one edge after the last merge.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int SLW = 3;
  typedef enum logic [SLW-1:0] {
    SL_LO8 = 3'd0,
    SL_HI8 = 3'd1,
    SL_W16 = 3'd2,
    SL_W32 = 3'd3,
    SL_W64 = 3'd4
  } slice_e;
endpackage

// File: rtl/prt_decode.sv
module prt_decode
  import prt_pkg::*;
#(
  parameter int NREG = 4,
  parameter int NSRC = 2,
  localparam int RW = $clog2(NREG)
) (
  input  logic              dst_vld,
  input  logic [RW-1:0]     dst_reg,
  input  logic [SLW-1:0]    dst_slice,
  input  logic              dst_rd,
  input  logic [NSRC-1:0]   src_vld,
  input  logic [NSRC*RW-1:0]  src_reg,
  input  logic [NSRC*SLW-1:0] src_slice,
  output logic [NREG-1:0]   rd_wide,
  output logic [NREG-1:0]   rd_hi,
  output logic [NREG-1:0]   wr_hi,
  output logic [NREG-1:0]   wr_w16,
  output logic [NREG-1:0]   wr_full
);
  logic dst_is_wide;
  assign dst_is_wide = dst_slice >= SLW'(SL_W16);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic src_w, src_h, dhit;
    always_comb begin
      src_w = 1'b0;
      src_h = 1'b0;
      for (int s = 0; s < NSRC; s++) begin
        if (src_vld[s] && src_reg[s*RW +: RW] == RW'(r)) begin
          if (src_slice[s*SLW +: SLW] >= SLW'(SL_W16)) src_w = 1'b1;
          else if (src_slice[s*SLW +: SLW] == SLW'(SL_HI8)) src_h = 1'b1;
        end
      end
    end
    assign dhit       = dst_vld && dst_reg == RW'(r);
    assign rd_wide[r] = src_w | (dhit & dst_rd & dst_is_wide);
    assign rd_hi[r]   = src_h | (dhit & dst_rd & (dst_slice == SLW'(SL_HI8)));
    assign wr_hi[r]   = dhit & (dst_slice == SLW'(SL_HI8));
    assign wr_w16[r]  = dhit & (dst_slice == SLW'(SL_W16));
    assign wr_full[r] = dhit & ((dst_slice == SLW'(SL_W32)) | (dst_slice == SLW'(SL_W64)));
  end
endmodule

// File: rtl/prt_pick.sv
module prt_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prt_dirty.sv
module prt_dirty #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            mrg_en,
  input  logic [RW-1:0]   mrg_idx,
  input  logic            upd_en,
  input  logic [NREG-1:0] set_vec,
  input  logic [NREG-1:0] clr_vec,
  output logic [NREG-1:0] dirty_q
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      dirty_q <= '0;
    end else if (mrg_en) begin
      dirty_q[mrg_idx] <= 1'b0;
    end else if (upd_en) begin
      dirty_q <= (dirty_q & ~clr_vec) | set_vec;
    end
  end
endmodule

// File: rtl/prt_merge_tracker.sv
module prt_merge_tracker
  import prt_pkg::*;
#(
  parameter int NREG = 4,
  parameter int NSRC = 2,
  localparam int RW = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic                  dst_vld,
  input  logic [RW-1:0]         dst_reg,
  input  logic [2:0]            dst_slice,
  input  logic                  dst_rd,
  input  logic [NSRC-1:0]       src_vld,
  input  logic [NSRC*RW-1:0]    src_reg,
  input  logic [NSRC*3-1:0]     src_slice,
  output logic                  iss_vld,
  output logic                  merge_vld,
  output logic [RW-1:0]         merge_reg,
  output logic                  extra_lat,
  output logic [NREG-1:0]       dirty
);
  logic [NREG-1:0] rd_wide, rd_hi, wr_hi, wr_w16, wr_full, need;
  logic            m_found, accept, do_merge, ext_nxt;
  logic [RW-1:0]   m_idx;

  prt_decode #(.NREG(NREG), .NSRC(NSRC)) u_dec (
    .dst_vld(dst_vld), .dst_reg(dst_reg), .dst_slice(dst_slice), .dst_rd(dst_rd),
    .src_vld(src_vld), .src_reg(src_reg), .src_slice(src_slice),
    .rd_wide(rd_wide), .rd_hi(rd_hi), .wr_hi(wr_hi), .wr_w16(wr_w16), .wr_full(wr_full)
  );

  assign need = dirty & (rd_wide | wr_w16) & {NREG{in_valid}};

  prt_pick #(.N(NREG)) u_pick (.req(need), .found(m_found), .idx(m_idx));

  assign in_ready = ~flush & ~m_found;
  assign accept   = in_valid & in_ready;
  assign do_merge = ~flush & m_found;
  assign ext_nxt  = |(rd_hi & ~dirty);

  prt_dirty #(.NREG(NREG)) u_dirty (
    .clk(clk), .rst(rst), .flush(flush),
    .mrg_en(do_merge), .mrg_idx(m_idx),
    .upd_en(accept), .set_vec(wr_hi), .clr_vec(wr_w16 | wr_full),
    .dirty_q(dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld   <= 1'b0;
      merge_vld <= 1'b0;
      merge_reg <= '0;
      extra_lat <= 1'b0;
    end else begin
      iss_vld   <= accept;
      merge_vld <= do_merge;
      merge_reg <= do_merge ? m_idx : '0;
      extra_lat <= accept & ext_nxt;
    end
  end
endmodule

// File: rtl/prt_merge_tracker_chk.sv
module prt_merge_tracker_chk #(
  parameter int NREG = 4,
  localparam int RW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            in_valid,
  input logic            in_ready,
  input logic            dst_vld,
  input logic [2:0]      dst_slice,
  input logic            iss_vld,
  input logic            merge_vld,
  input logic [RW-1:0]   merge_reg,
  input logic [NREG-1:0] dirty
);
  AST_STALL_GIVES_MERGE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && !flush) |=> merge_vld); // R4
  AST_MERGE_CLEARS_BIT: assert property (@(posedge clk) disable iff (rst)
    merge_vld |-> !dirty[merge_reg]); // R4
  AST_MERGE_NOT_ISSUE: assert property (@(posedge clk) disable iff (rst)
    merge_vld |-> !iss_vld); // R10
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> (dirty == '0 && !iss_vld && !merge_vld)); // R9
  AST_SET_ONLY_BY_ISSUE: assert property (@(posedge clk) disable iff (rst)
    ((dirty & ~$past(dirty)) != '0) |-> iss_vld); // R2
  AST_LOW8_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (!dst_vld || dst_slice == 3'd0)) |=> $stable(dirty)); // R1
endmodule

bind prt_merge_tracker prt_merge_tracker_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/prt_merge_tracker_bench.sv
`timescale 1ns/1ps
module prt_merge_tracker_bench;
  localparam int NREG = 4;
  localparam int NSRC = 2;
  localparam int RW = 2;
  localparam logic [2:0] LO = 3'd0, HI = 3'd1, W16 = 3'd2, W32 = 3'd3, W64 = 3'd4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic dst_vld = 1'b0;
  logic [RW-1:0] dst_reg = '0;
  logic [2:0] dst_slice = '0;
  logic dst_rd = 1'b0;
  logic [NSRC-1:0] src_vld = '0;
  logic [NSRC*RW-1:0] src_reg = '0;
  logic [NSRC*3-1:0] src_slice = '0;
  logic iss_vld, merge_vld, extra_lat;
  logic [RW-1:0] merge_reg;
  logic [NREG-1:0] dirty;

  always #10 clk = ~clk;

  prt_merge_tracker #(.NREG(NREG), .NSRC(NSRC)) u_prt_merge_tracker (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .dst_vld(dst_vld), .dst_reg(dst_reg), .dst_slice(dst_slice), .dst_rd(dst_rd),
    .src_vld(src_vld), .src_reg(src_reg), .src_slice(src_slice),
    .iss_vld(iss_vld), .merge_vld(merge_vld), .merge_reg(merge_reg),
    .extra_lat(extra_lat), .dirty(dirty)
  );

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R9";
  bit md[NREG];
  int e_iss = 0, e_mrg = 0, e_mreg = 0, e_ext = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int mvec();
    int v = 0;
    for (int r = 0; r < NREG; r++) if (md[r]) v += (1 << r);
    return v;
  endfunction

  task automatic check_regs();
    chk(iss_vld == e_iss[0], "iss_vld", int'(iss_vld), e_iss);
    chk(merge_vld == e_mrg[0], "merge_vld", int'(merge_vld), e_mrg);
    chk(int'(merge_reg) == e_mreg, "merge_reg", int'(merge_reg), e_mreg);
    chk(extra_lat == e_ext[0], "extra_lat", int'(extra_lat), e_ext);
    chk(int'(dirty) == mvec(), "dirty", int'(dirty), mvec());
  endtask

  // one cycle: behavioural reference step, then compare
  task automatic tick(output bit acc);
    int first = -1;
    bit rdy, ext;
    bit nd[NREG];
    #1;
    for (int r = 0; r < NREG; r++) begin
      bit uses = 1'b0;
      for (int s = 0; s < NSRC; s++)
        if (src_vld[s] && int'(src_reg[s*RW +: RW]) == r && src_slice[s*3 +: 3] >= W16) uses = 1'b1;
      if (dst_vld && int'(dst_reg) == r && (dst_slice == W16 || (dst_rd && dst_slice >= W16))) uses = 1'b1;
      if (in_valid && md[r] && uses && first < 0) first = r;
    end
    rdy = !flush && first < 0;
    chk(in_ready == rdy, "in_ready", int'(in_ready), int'(rdy));
    acc = in_valid && rdy;
    ext = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (src_vld[s] && src_slice[s*3 +: 3] == HI && !md[src_reg[s*RW +: RW]]) ext = 1'b1;
    if (dst_vld && dst_rd && dst_slice == HI && !md[dst_reg]) ext = 1'b1;
    ext = ext && acc;
    nd = md;
    if (flush) begin
      for (int r = 0; r < NREG; r++) nd[r] = 1'b0;
    end else if (first >= 0) begin
      nd[first] = 1'b0;
    end else if (acc && dst_vld) begin
      if (dst_slice == HI) nd[dst_reg] = 1'b1;
      else if (dst_slice >= W16) nd[dst_reg] = 1'b0;
    end
    @(posedge clk);
    md = nd;
    e_iss = int'(acc);
    e_mrg = int'(!flush && first >= 0);
    e_mreg = (!flush && first >= 0) ? first : 0;
    e_ext = int'(ext);
    @(negedge clk);
    check_regs();
  endtask

  task automatic send(input bit dv, input int dr, input logic [2:0] ds, input bit drd,
                      input bit s0v, input int s0r, input logic [2:0] s0s,
                      input bit s1v, input int s1r, input logic [2:0] s1s);
    bit acc = 1'b0;
    in_valid = 1'b1;
    dst_vld = dv; dst_reg = RW'(dr); dst_slice = ds; dst_rd = drd;
    src_vld = {s1v, s0v};
    src_reg = {RW'(s1r), RW'(s0r)};
    src_slice = {s1s, s0s};
    for (int g = 0; g < 8 && !acc; g++) tick(acc);
    chk(acc, "accepted", int'(acc), 1);
    in_valid = 1'b0;
  endtask

  task automatic idle();
    bit acc;
    in_valid = 1'b0;
    tick(acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) md[r] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R9";
    #1;
    chk(in_ready == 1'b1, "reset in_ready", int'(in_ready), 1);
    check_regs();
    @(negedge clk);

    cur_req = "R1";
    send(1, 0, LO, 0, 0, 0, LO, 0, 0, LO);
    send(1, 0, LO, 1, 1, 1, LO, 0, 0, LO);
    send(1, 2, W32, 0, 1, 0, LO, 0, 0, LO);

    cur_req = "R2";
    send(1, 0, HI, 0, 1, 3, LO, 0, 0, LO);

    cur_req = "R1";
    send(1, 0, LO, 1, 1, 0, LO, 0, 0, LO);

    cur_req = "R7";
    send(1, 2, LO, 0, 1, 0, HI, 0, 0, LO);
    send(1, 2, LO, 0, 1, 1, HI, 0, 0, LO);

    cur_req = "R3";
    send(1, 0, HI, 1, 0, 0, LO, 0, 0, LO);
    send(1, 1, HI, 1, 1, 3, LO, 0, 0, LO);

    cur_req = "R8";
    for (int k = 0; k < 6; k++) idle();
    for (int k = 0; k < 6; k++) send(1, 3, W32, 0, 1, 2, W64, 0, 0, LO);

    cur_req = "R4";
    send(1, 2, W32, 0, 1, 0, W32, 0, 0, LO);

    cur_req = "R5";
    send(1, 1, W64, 0, 0, 0, LO, 0, 0, LO);

    cur_req = "R6";
    send(1, 2, HI, 0, 0, 0, LO, 0, 0, LO);
    send(1, 2, W16, 0, 0, 0, LO, 0, 0, LO);

    cur_req = "R10";
    send(1, 3, HI, 0, 0, 0, LO, 0, 0, LO);
    send(1, 1, HI, 0, 0, 0, LO, 0, 0, LO);
    send(1, 0, W64, 0, 1, 3, W64, 1, 1, W16);

    cur_req = "R9";
    send(1, 2, HI, 0, 0, 0, LO, 0, 0, LO);
    begin
      bit acc;
      flush = 1'b1;
      in_valid = 1'b1;
      dst_vld = 1'b1; dst_reg = 2'd0; dst_slice = W32; dst_rd = 1'b0;
      src_vld = 2'b01; src_reg = {2'd0, 2'd2}; src_slice = {LO, W64};
      tick(acc);
      flush = 1'b0;
      in_valid = 1'b0;
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule